// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block is a small direct-indexed table that a fetch stage consults on every fetch address, in the same cycle, before anyone knows whether the fetched word is a branch at all. Each slot holds the full address of a branch that was seen to jump, the address it jumped to, and a two-bit saturating confidence counter. When the fetch address matches a valid slot whose counter sits in the taken half, the block returns the stored target as the next fetch address. In every other case it returns the sequential address.

The execute stage reports each resolved instruction back through a resolve port. The report carries the instruction address, a flag that marks it as a branch, the real direction and the real target. A taken branch that is missing from the table is given a slot, replacing whatever used that slot before. A present branch that jumps again gains confidence and has its target refreshed. A present branch that falls through costs confidence, and the slot is dropped once confidence leaves the strong level.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous active-low reset no slot is valid, so every fetch address misses until an allocation happens.
- R2: A fetch address misses (pred_hit=0, pred_taken=0) unless a valid slot at its index holds the identical full address. On a miss, pred_next_pc equals fetch_pc + 4. This also applies when a different address shares the index.
- R3: The index is fetch_pc bits [IDX_W+1:2]. On a hit whose counter has its upper bit set (value 2 or 3), pred_taken=1 and pred_next_pc is the stored target.
- R4: A resolved branch (res_valid=1, res_is_branch=1) that is taken and missing from the table is written into its slot with its address, its target and counter value 2 (weakly taken).
- R5: A resolved branch that is not taken and missing from the table leaves the table unchanged.
- R6: A resolved taken branch that is present raises its counter by one, saturating at 3, and replaces the stored target with the reported one.
- R7: A resolved not-taken branch that is present with counter 3 drops to counter 2 and stays valid, so it still predicts taken.
- R8: A resolved not-taken branch that is present with counter 2 has its slot invalidated.
- R9: A report with res_valid=0, or with res_is_branch=0, changes nothing.
- R10: A lookup in the same cycle as an update to the same slot sees the old contents. The update is visible from the next clock edge on.
- R11: Allocating an address into a slot held by another address evicts the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_hit | output | 1 | A valid slot matches fetch_pc |
| pred_taken | output | 1 | The matching slot predicts taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| res_valid | input | 1 | A resolve report is present this cycle |
| res_is_branch | input | 1 | The resolved instruction is a branch |
| res_pc | input | ADDR_W | Address of the resolved instruction |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_target | input | ADDR_W | Real target of the resolved branch |

## Verification
The bench checks the confidence counter only through the prediction it causes. A freshly allocated slot must vanish after a single fall-through. A slot that jumped once more must survive one fall-through and vanish on the second. A slot driven past saturation must do the same; a counter that wrapped past 3 would stop predicting at once. Two addresses are placed on one index: a design that compared only index bits would wrongly hit for the alias, and one that skipped eviction would keep the old owner. A resolve and a lookup to the same slot in one cycle catch a write-through path that exposes new contents too early. Non-branch and invalid reports that carry a not-taken direction catch an update path that ignores the qualifying flags.

// File: rtl/btb_pkg.sv
// Package: shared constants and helpers for the branch target predictor.
// Assumes fixed 4-byte instructions and a two-bit confidence counter.
package btb_pkg;
    localparam int INSTR_BYTES = 4;
    localparam int OFFSET_W    = $clog2(INSTR_BYTES);
    localparam int CTR_W       = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_WEAK_TAKEN   = 2'b10;
    localparam ctr_t CTR_STRONG_TAKEN = 2'b11;

    // Saturating increment of the confidence counter.
    function automatic ctr_t ctr_up(input ctr_t c);
        return (c == CTR_STRONG_TAKEN) ? c : ctr_t'(c + 1'b1);
    endfunction

    // Saturating decrement of the confidence counter.
    function automatic ctr_t ctr_down(input ctr_t c);
        return (c == '0) ? c : ctr_t'(c - 1'b1);
    endfunction
endpackage

// File: rtl/btb_table.sv
// Module: storage array of the predictor with NUM_RD combinational read
// ports and one synchronous write port. Only valid bits are reset; the
// payload of a slot is written only when the slot is (re)validated.
// Assumes a single writer per cycle; reads return pre-edge contents.
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int NUM_RD = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0]             rd_valid,
    output logic [NUM_RD-1:0][ADDR_W-1:0] rd_tag,
    output logic [NUM_RD-1:0][ADDR_W-1:0] rd_tgt,
    output logic [NUM_RD-1:0][CTR_W-1:0]  rd_ctr,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_valid,
    input  logic [ADDR_W-1:0]             wr_tag,
    input  logic [ADDR_W-1:0]             wr_tgt,
    input  logic [CTR_W-1:0]              wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];
    ctr_t              ctr_q [DEPTH];

    // Valid bits: cleared by reset, set or cleared by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    // Payload: written only when the slot stays or becomes valid.
    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
            ctr_q[wr_idx] <= wr_ctr;
        end
    end

    // One identical combinational read path per read port.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_valid[p] = valid_q[rd_idx[p]];
            rd_tag[p]   = tag_q[rd_idx[p]];
            rd_tgt[p]   = tgt_q[rd_idx[p]];
            rd_ctr[p]   = ctr_q[rd_idx[p]];
        end
    end

    // R4, R8: a write lands in the addressed slot's valid bit at the next edge.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));

    // R1: the cycle after reset no slot is valid.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/btb_update_ctl.sv
// Module: decides how a resolve report changes the table. It reads the
// slot at the reported address's index and produces at most one write.
// Assumes rd_* describe the slot selected by the resolved address.
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic              res_is_branch,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_tag,
    input  logic [ADDR_W-1:0] rd_tgt,
    input  logic [CTR_W-1:0]  rd_ctr,
    output logic              wr_en,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_tag,
    output logic [ADDR_W-1:0] wr_tgt,
    output logic [CTR_W-1:0]  wr_ctr
);
    logic present;
    logic report;

    // Qualify the report and look for the resolved address in its slot.
    always_comb begin
        report  = res_valid && res_is_branch;
        present = rd_valid && (rd_tag == res_pc);
    end

    // Allocation, strengthening, weakening and eviction policy.
    always_comb begin
        wr_en    = 1'b0;
        wr_valid = 1'b0;
        wr_tag   = res_pc;
        wr_tgt   = res_target;
        wr_ctr   = CTR_WEAK_TAKEN;
        if (report) begin
            if (present && res_taken) begin
                wr_en    = 1'b1;
                wr_valid = 1'b1;
                wr_ctr   = ctr_up(rd_ctr);
            end else if (present && (rd_ctr == CTR_STRONG_TAKEN)) begin
                wr_en    = 1'b1;
                wr_valid = 1'b1;
                wr_tgt   = rd_tgt;
                wr_ctr   = ctr_down(rd_ctr);
            end else if (present) begin
                wr_en    = 1'b1;
                wr_valid = 1'b0;
            end else if (res_taken) begin
                wr_en    = 1'b1;
                wr_valid = 1'b1;
            end
        end
    end

    // R9: reports that are not valid branches never write.
    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_is_branch) |-> !wr_en);

    // R5: a missing branch that falls through never writes.
    a_r5_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_branch && !res_taken && !present) |-> !wr_en);

    // R6: strengthening a strong slot keeps it at the top, no wrap.
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_branch && res_taken && present
         && rd_ctr == CTR_STRONG_TAKEN) |-> (wr_ctr == CTR_STRONG_TAKEN));
endmodule

// File: rtl/btb_lookup.sv
// Module: fetch-side compare and next-address select. Purely
// combinational so the prediction is ready in the fetch cycle.
// Assumes the slot fields come from the fetch address's index.
module btb_lookup
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              slot_valid,
    input  logic [ADDR_W-1:0] slot_tag,
    input  logic [ADDR_W-1:0] slot_tgt,
    input  logic [CTR_W-1:0]  slot_ctr,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    // Full-address match, direction from the counter's upper bit.
    always_comb begin
        hit     = slot_valid && (slot_tag == fetch_pc);
        taken   = hit && slot_ctr[CTR_W-1];
        next_pc = taken ? slot_tgt : fetch_pc + ADDR_W'(INSTR_BYTES);
    end
endmodule

// File: rtl/btb_predictor.sv
// Module: top of the branch target predictor. Port 0 of the table serves
// the fetch lookup, port 1 serves the resolve path.
// Assumes aligned 4-byte fetch addresses and one report per cycle.
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              res_valid,
    input  logic              res_is_branch,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target
);
    localparam int NUM_RD  = 2;
    localparam int PORT_FE = 0;
    localparam int PORT_RS = 1;

    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0]             rd_valid;
    logic [NUM_RD-1:0][ADDR_W-1:0] rd_tag;
    logic [NUM_RD-1:0][ADDR_W-1:0] rd_tgt;
    logic [NUM_RD-1:0][CTR_W-1:0]  rd_ctr;

    logic              wr_en;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_tag;
    logic [ADDR_W-1:0] wr_tgt;
    logic [CTR_W-1:0]  wr_ctr;

    // Index from the low address bits above the byte offset.
    always_comb begin
        rd_idx[PORT_FE] = fetch_pc[OFFSET_W +: IDX_W];
        rd_idx[PORT_RS] = res_pc[OFFSET_W +: IDX_W];
    end

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_RD(NUM_RD)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_ctr   (rd_ctr),
        .wr_en    (wr_en),
        .wr_idx   (rd_idx[PORT_RS]),
        .wr_valid (wr_valid),
        .wr_tag   (wr_tag),
        .wr_tgt   (wr_tgt),
        .wr_ctr   (wr_ctr)
    );

    btb_update_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_update (
        .clk           (clk),
        .rst_n         (rst_n),
        .res_valid     (res_valid),
        .res_is_branch (res_is_branch),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target),
        .rd_valid      (rd_valid[PORT_RS]),
        .rd_tag        (rd_tag[PORT_RS]),
        .rd_tgt        (rd_tgt[PORT_RS]),
        .rd_ctr        (rd_ctr[PORT_RS]),
        .wr_en         (wr_en),
        .wr_valid      (wr_valid),
        .wr_tag        (wr_tag),
        .wr_tgt        (wr_tgt),
        .wr_ctr        (wr_ctr)
    );

    btb_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .fetch_pc   (fetch_pc),
        .slot_valid (rd_valid[PORT_FE]),
        .slot_tag   (rd_tag[PORT_FE]),
        .slot_tgt   (rd_tgt[PORT_FE]),
        .slot_ctr   (rd_ctr[PORT_FE]),
        .hit        (pred_hit),
        .taken      (pred_taken),
        .next_pc    (pred_next_pc)
    );

    // R2: whenever no jump is predicted the next address is sequential.
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_next_pc == fetch_pc + ADDR_W'(INSTR_BYTES)));

    // R3: a taken prediction always comes from a hit.
    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);
endmodule

// File: tb/btb_predictor_bench.sv
// Directed bench: each task starts from reset, drives one scenario and
// checks the prediction ports. Inputs change at the falling edge and
// outputs are sampled 1 time unit later, before the next rising edge.
module btb_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    localparam logic [AW-1:0] PC_A = 32'h0000_1000; // index 0
    localparam logic [AW-1:0] PC_B = 32'h0000_1040; // index 0, alias of A
    localparam logic [AW-1:0] PC_C = 32'h0000_2008; // index 2
    localparam logic [AW-1:0] PC_D = 32'h0000_2400; // index 0

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_hit;
    logic          pred_taken;
    logic [AW-1:0] pred_next_pc;
    logic          res_valid = 1'b0;
    logic          res_is_branch = 1'b0;
    logic [AW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_target = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    btb_predictor u_btb_predictor (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_pc      (fetch_pc),
        .pred_hit      (pred_hit),
        .pred_taken    (pred_taken),
        .pred_next_pc  (pred_next_pc),
        .res_valid     (res_valid),
        .res_is_branch (res_is_branch),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare(input string req, input logic e_hit,
                           input logic e_tkn, input logic [AW-1:0] e_next);
        n_checks++;
        if (pred_hit !== e_hit || pred_taken !== e_tkn || pred_next_pc !== e_next) begin
            n_fails++;
            $display("FAIL %s: hit/taken/next = %b/%b/%h, expected %b/%b/%h",
                     req, pred_hit, pred_taken, pred_next_pc, e_hit, e_tkn, e_next);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic look(input logic [AW-1:0] pc, input string req,
                        input logic e_hit, input logic e_tkn, input logic [AW-1:0] e_next);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        compare(req, e_hit, e_tkn, e_next);
    endtask

    task automatic resolve(input logic vld, input logic br, input logic [AW-1:0] pc,
                           input logic tkn, input logic [AW-1:0] tgt);
        @(negedge clk);
        res_valid = vld;
        res_is_branch = br;
        res_pc = pc;
        res_taken = tkn;
        res_target = tgt;
        @(posedge clk);
        #1;
        res_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        look(PC_A, "R1 reset", 1'b0, 1'b0, PC_A + 4);
        look(PC_C, "R1 reset", 1'b0, 1'b0, PC_C + 4);
    endtask

    task automatic t_alloc_and_alias();
        do_reset();
        resolve(1'b1, 1'b1, PC_A, 1'b1, 32'h3000);
        look(PC_A, "R4 alloc / R3 hit", 1'b1, 1'b1, 32'h3000);
        look(PC_B, "R2 alias miss", 1'b0, 1'b0, PC_B + 4);
    endtask

    task automatic t_no_alloc_not_taken();
        do_reset();
        resolve(1'b1, 1'b1, PC_C, 1'b0, 32'h4000);
        look(PC_C, "R5 no alloc", 1'b0, 1'b0, PC_C + 4);
    endtask

    task automatic t_weak_evict();
        do_reset();
        resolve(1'b1, 1'b1, PC_A, 1'b1, 32'h3000);
        resolve(1'b1, 1'b1, PC_A, 1'b0, 32'h0);
        look(PC_A, "R8 weak evict", 1'b0, 1'b0, PC_A + 4);
    endtask

    task automatic t_strong_hysteresis();
        do_reset();
        resolve(1'b1, 1'b1, PC_A, 1'b1, 32'h3000);
        resolve(1'b1, 1'b1, PC_A, 1'b1, 32'h3100);
        look(PC_A, "R6 target refresh", 1'b1, 1'b1, 32'h3100);
        resolve(1'b1, 1'b1, PC_A, 1'b0, 32'h0);
        look(PC_A, "R7 strong keeps", 1'b1, 1'b1, 32'h3100);
        resolve(1'b1, 1'b1, PC_A, 1'b0, 32'h0);
        look(PC_A, "R8 second fallthrough", 1'b0, 1'b0, PC_A + 4);
    endtask

    task automatic t_saturation();
        do_reset();
        for (int i = 0; i < 4; i++) resolve(1'b1, 1'b1, PC_C, 1'b1, 32'h5000);
        resolve(1'b1, 1'b1, PC_C, 1'b0, 32'h0);
        look(PC_C, "R6 saturate at 3", 1'b1, 1'b1, 32'h5000);
        resolve(1'b1, 1'b1, PC_C, 1'b0, 32'h0);
        look(PC_C, "R6 saturate evict", 1'b0, 1'b0, PC_C + 4);
    endtask

    task automatic t_ignored_reports();
        do_reset();
        resolve(1'b1, 1'b1, PC_C, 1'b1, 32'h6000);
        resolve(1'b1, 1'b0, PC_C, 1'b0, 32'h0);
        look(PC_C, "R9 non-branch", 1'b1, 1'b1, 32'h6000);
        resolve(1'b0, 1'b1, PC_C, 1'b0, 32'h0);
        look(PC_C, "R9 not valid", 1'b1, 1'b1, 32'h6000);
        resolve(1'b1, 1'b0, PC_B, 1'b1, 32'h7000);
        look(PC_B, "R9 non-branch no alloc", 1'b0, 1'b0, PC_B + 4);
    endtask

    task automatic t_same_cycle();
        do_reset();
        @(negedge clk);
        fetch_pc = PC_D;
        res_valid = 1'b1;
        res_is_branch = 1'b1;
        res_pc = PC_D;
        res_taken = 1'b1;
        res_target = 32'h8000;
        #1;
        compare("R10 old contents", 1'b0, 1'b0, PC_D + 4);
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        compare("R10 new contents", 1'b1, 1'b1, 32'h8000);
    endtask

    task automatic t_conflict();
        do_reset();
        resolve(1'b1, 1'b1, PC_A, 1'b1, 32'h3000);
        resolve(1'b1, 1'b1, PC_B, 1'b1, 32'h9000);
        look(PC_B, "R11 new owner", 1'b1, 1'b1, 32'h9000);
        look(PC_A, "R11 old evicted", 1'b0, 1'b0, PC_A + 4);
    endtask

    initial begin
        t_reset_state();
        t_alloc_and_alias();
        t_no_alloc_not_taken();
        t_weak_evict();
        t_strong_hysteresis();
        t_saturation();
        t_ignored_reports();
        t_same_cycle();
        t_conflict();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule